// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock line for an I2C master. It divides the peripheral input clock by a programmed 12-bit count. A speed-mode bit and a duty bit pick one of three ratios between the high and low phases of SCL. The block pulls SCL low through an open-drain drive enable and otherwise leaves the line released. The phase counters are clocked by the peripheral clock.

A control word holds the speed mode in bit 15, the duty select in bit 14 and the count in bits 11:0. Bits 13:12 always read back as zero. The speed mode is standard when bit 15 is 0 and fast when it is 1. The duty select matters only in fast mode: 0 gives a 1:2 high:low ratio and 1 gives a 9:16 ratio.

A master flag is set by a start request and cleared by a stop, by a loss of arbitration, or by dropping the enable. While the flag is set the generator runs. It begins with a low phase, then alternates high and low phases. The state machine has three states:

- `ST_IDLE`: SCL released.
- `ST_LOW`: SCL driven low.
- `ST_HIGH`: SCL released, with the phase counter running.

The transitions are:

- start: `ST_IDLE` to `ST_LOW`.
- low_done: `ST_LOW` to `ST_HIGH` when the low count expires.
- high_done: `ST_HIGH` to `ST_LOW` when the high count expires while SCL reads high.
- halt: any state to `ST_IDLE` on stop, arbitration loss or enable low.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, `scl_drive_low`, `master`, `busy` and `ctrl_rdata` are all 0.
- R2: `ctrl_rdata` returns the last written word with bits 13:12 forced to 0 (writing 0xFFFF reads 0xCFFF).
- R3: In standard mode (bit 15 = 0) each low phase and each high phase lasts C input-clock cycles, where C is the effective count.
- R4: In fast mode with duty bit 14 = 0, the high phase lasts C cycles and the low phase lasts 2C cycles.
- R5: In fast mode with duty bit 14 = 1, the high phase lasts 9C cycles and the low phase lasts 16C cycles.
- R6: The effective count C is the programmed count, raised to a minimum of 4. In fast mode with duty 1 the minimum is 1 instead. Programmed values of 0 up to the minimum act as the minimum.
- R7: A start request while enabled and idle sets `master` and `busy` and drives SCL low in the next cycle. A start request while the enable is low has no effect.
- R8: A stop request, an arbitration-loss pulse or a low enable clears `master` and `busy` and releases SCL in the next cycle.
- R9: A write to the control word during a phase leaves that phase's length unchanged. The new setting applies from the next phase on.
- R10: During a high phase, the cycles in which `scl_in` reads low are not counted. SCL stays released until the high count has been met with the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Control word readback |
| start_req | input | 1 | Start condition request pulse |
| stop_req | input | 1 | Stop condition pulse |
| arb_lost | input | 1 | Arbitration-loss pulse |
| scl_in | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | Open-drain drive enable, 1 pulls SCL low |
| master | output | 1 | Master-mode flag |
| busy | output | 1 | Generator running |

## Verification
A wrong phase count, ratio or clamp shows as a wrong run length of `scl_drive_low` within one SCL period. The bench measures both phases of a whole period. A state machine stuck outside `ST_IDLE` would show one cycle after a stop, as SCL still driven or `master` still set. A counter that ran while the line was held low would end the high phase early, and the bench would see this in the same period. A configuration taken mid-phase would change the length of the phase already in progress.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    localparam int CCR_W = 12;
    localparam int CNT_W = CCR_W + 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

    typedef struct packed {
        logic             fast;
        logic             duty;
        logic [CCR_W-1:0] ccr;
    } scl_cfg_t;
endpackage

// File: rtl/i2c_scl_ctrl_reg.sv
module i2c_scl_ctrl_reg
    import i2c_scl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [15:0]          wdata,
    output scl_cfg_t             cfg,
    output logic [15:0]          rdata
);
    localparam int FAST_BIT = 15;
    localparam int DUTY_BIT = 14;
    localparam int PAD_W    = 14 - CCR_W;

    scl_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.fast <= wdata[FAST_BIT];
            cfg_q.duty <= wdata[DUTY_BIT];
            cfg_q.ccr  <= wdata[CCR_W-1:0];
        end
    end

    assign cfg   = cfg_q;
    assign rdata = {cfg_q.fast, cfg_q.duty, {PAD_W{1'b0}}, cfg_q.ccr};
endmodule

// File: rtl/i2c_scl_phase_calc.sv
module i2c_scl_phase_calc
    import i2c_scl_pkg::*;
(
    input  scl_cfg_t          cfg,
    output logic [CNT_W-1:0]  high_len,
    output logic [CNT_W-1:0]  low_len
);
    localparam logic [CCR_W-1:0] MIN_NORM = CCR_W'(4);
    localparam logic [CCR_W-1:0] MIN_DUTY = CCR_W'(1);

    logic             wide_duty;
    logic [CCR_W-1:0] floor_val;
    logic [CCR_W-1:0] ccr_eff;
    logic [CNT_W-1:0] c;

    always_comb begin
        wide_duty = cfg.fast & cfg.duty;
        floor_val = wide_duty ? MIN_DUTY : MIN_NORM;
        ccr_eff   = (cfg.ccr < floor_val) ? floor_val : cfg.ccr;
        c         = CNT_W'(ccr_eff);
        if (wide_duty) begin
            high_len = (c << 3) + c;
            low_len  = c << 4;
        end else if (cfg.fast) begin
            high_len = c;
            low_len  = c << 1;
        end else begin
            high_len = c;
            low_len  = c;
        end
    end
endmodule

// File: rtl/i2c_scl_master_flag.sv
module i2c_scl_master_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_req,
    input  logic stop_req,
    input  logic arb_lost,
    output logic halt,
    output logic start_go,
    output logic master
);
    logic master_q;

    assign halt     = stop_req | arb_lost | ~enable;
    assign start_go = start_req & ~halt & ~master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
        end else if (halt) begin
            master_q <= 1'b0;
        end else if (start_go) begin
            master_q <= 1'b1;
        end
    end

    assign master = master_q;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        ctrl_wr,
    input  logic [15:0] ctrl_wdata,
    output logic [15:0] ctrl_rdata,
    input  logic        start_req,
    input  logic        stop_req,
    input  logic        arb_lost,
    input  logic        scl_in,
    output logic        scl_drive_low,
    output logic        master,
    output logic        busy
);
    scl_cfg_t         cfg;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] low_len;
    logic             halt;
    logic             start_go;

    scl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    i2c_scl_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .cfg   (cfg),
        .rdata (ctrl_rdata)
    );

    i2c_scl_phase_calc u_calc (
        .cfg      (cfg),
        .high_len (high_len),
        .low_len  (low_len)
    );

    i2c_scl_master_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start_req (start_req),
        .stop_req  (stop_req),
        .arb_lost  (arb_lost),
        .halt      (halt),
        .start_go  (start_go),
        .master    (master)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state; lengths are sampled only on phase entry
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (halt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_go) begin
                        state_d = ST_LOW;
                        cnt_d   = low_len - CNT_W'(1);
                    end
                end
                ST_LOW: begin
                    if (cnt_q == '0) begin
                        state_d = ST_HIGH;
                        cnt_d   = high_len - CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (scl_in) begin
                        if (cnt_q == '0) begin
                            state_d = ST_LOW;
                            cnt_d   = low_len - CNT_W'(1);
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_drive_low = (state_q == ST_LOW);
        busy          = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        start_req,
    input logic        stop_req,
    input logic        arb_lost,
    input logic        scl_in,
    input logic [15:0] ctrl_rdata,
    input logic        scl_drive_low,
    input logic        master,
    input logic        busy
);
    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[13:12] == 2'b00);

    // R7
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && enable && !stop_req && !arb_lost && !busy)
        |=> (scl_drive_low && master && busy));

    // R8
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || arb_lost || !enable)
        |=> (!scl_drive_low && !master && !busy));

    // R10
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !scl_drive_low && !scl_in) |=> !scl_drive_low);

    // R7
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master == busy);

    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scl_drive_low);
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .arb_lost      (arb_lost),
    .scl_in        (scl_in),
    .ctrl_rdata    (ctrl_rdata),
    .scl_drive_low (scl_drive_low),
    .master        (master),
    .busy          (busy)
);

// File: tb/i2c_scl_gen_tb.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        arb_lost = 1'b0;
    logic        ext_hold = 1'b0;
    logic        scl_in;
    logic        scl_drive_low;
    logic        master;
    logic        busy;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    assign scl_in = ~(scl_drive_low | ext_hold);

    i2c_scl_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .ctrl_rdata    (ctrl_rdata),
        .start_req     (start_req),
        .stop_req      (stop_req),
        .arb_lost      (arb_lost),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .master        (master),
        .busy          (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        @(negedge clk);
    endtask

    // Measures one full low phase then the following high phase
    task automatic measure(input int holdn, output int lo, output int hi);
        do @(negedge clk); while (scl_drive_low !== 1'b0);
        do @(negedge clk); while (scl_drive_low !== 1'b1);
        lo = 0;
        while (scl_drive_low === 1'b1) begin
            lo++;
            @(negedge clk);
        end
        hi = 0;
        while (scl_drive_low === 1'b0) begin
            hi++;
            if (hi == 1 && holdn > 0) ext_hold = 1'b1;
            if (hi == holdn + 1) ext_hold = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input logic [15:0] w, input int holdn, input string req,
                            input int exp_lo, input int exp_hi);
        int lo, hi;
        write_cfg(w);
        pulse_start();
        measure(holdn, lo, hi);
        chk(lo == exp_lo, {req, " low"}, lo, exp_lo);
        chk(hi == exp_hi, {req, " high"}, hi, exp_hi);
        do_stop();
    endtask

    task automatic t_reset();
        chk(scl_drive_low == 1'b0, "R1 drive", int'(scl_drive_low), 0);
        chk(master == 1'b0, "R1 master", int'(master), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(ctrl_rdata == 16'h0000, "R1 rdata", int'(ctrl_rdata), 0);
    endtask

    task automatic t_regs();
        write_cfg(16'hFFFF);
        chk(ctrl_rdata == 16'hCFFF, "R2 pad bits", int'(ctrl_rdata), 'hCFFF);
        write_cfg(16'h3028);
        chk(ctrl_rdata == 16'h0028, "R2 readback", int'(ctrl_rdata), 'h0028);
    endtask

    task automatic t_modes();
        run_case(16'h0028, 0, "R3 std", 40, 40);
        run_case(16'h8006, 0, "R4 fast d0", 12, 6);
        run_case(16'hC003, 0, "R5 fast d1", 48, 27);
    endtask

    task automatic t_clamp();
        run_case(16'h0001, 0, "R6 std ccr1", 4, 4);
        run_case(16'h8000, 0, "R6 fast ccr0", 8, 4);
        run_case(16'hC001, 0, "R6 duty ccr1", 16, 9);
        run_case(16'hC000, 0, "R6 duty ccr0", 16, 9);
    endtask

    task automatic t_start();
        write_cfg(16'h0005);
        enable = 1'b0;
        pulse_start();
        chk(master == 1'b0, "R7 start while disabled", int'(master), 0);
        chk(scl_drive_low == 1'b0, "R7 no drive while disabled", int'(scl_drive_low), 0);
        enable = 1'b1;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk(scl_drive_low == 1'b1, "R7 low phase first", int'(scl_drive_low), 1);
        chk(master == 1'b1 && busy == 1'b1, "R7 master set", int'(master), 1);
        do_stop();
    endtask

    task automatic t_halt();
        write_cfg(16'h0008);
        pulse_start();
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(!master && !busy && !scl_drive_low, "R8 stop", int'(master), 0);
        repeat (20) @(negedge clk);
        chk(scl_drive_low == 1'b0, "R8 stays released", int'(scl_drive_low), 0);

        pulse_start();
        @(negedge clk);
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
        chk(!master && !busy && !scl_drive_low, "R8 arb lost", int'(master), 0);

        pulse_start();
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!master && !busy && !scl_drive_low, "R8 disable", int'(master), 0);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_change();
        int lo, hi, lo2, hi2;
        write_cfg(16'h000A);
        pulse_start();
        do @(negedge clk); while (scl_drive_low !== 1'b0);
        do @(negedge clk); while (scl_drive_low !== 1'b1);
        lo = 0;
        while (scl_drive_low === 1'b1) begin
            lo++;
            if (lo == 3) begin
                ctrl_wr = 1'b1;
                ctrl_wdata = 16'h0014;
            end
            if (lo == 4) ctrl_wr = 1'b0;
            @(negedge clk);
        end
        ctrl_wr = 1'b0;
        hi = 0;
        while (scl_drive_low === 1'b0) begin
            hi++;
            @(negedge clk);
        end
        chk(lo == 10, "R9 current phase kept", lo, 10);
        chk(hi == 20, "R9 next phase new", hi, 20);
        measure(0, lo2, hi2);
        chk(lo2 == 20 && hi2 == 20, "R9 later period", lo2, 20);
        do_stop();
    endtask

    task automatic t_hold();
        run_case(16'h0005, 7, "R10 hold", 5, 12);
        run_case(16'h8004, 3, "R10 hold fast", 8, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_regs();
        t_modes();
        t_clamp();
        t_start();
        t_halt();
        t_change();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule